// File: doc/BRIEF.md
# Carry-Save Montgomery Modular Multiplier

This block forms the Montgomery product of two k-bit operands: given x, y and an odd modulus n, it returns a value congruent to x·y·2^-(k+2) modulo n. It is the inner engine of a modular exponentiator. The surrounding controller prepares the Montgomery constants and applies any final subtraction. The result is only partly reduced: it is always below 2n.

The multiplier scans one bit of x per clock. It keeps the running partial product as two carry-save vector pairs, so no wide carry chain appears inside the loop. After k+2 scan steps, a 32-bit adder folds the sum and carry vectors into a binary result, one 32-bit slice per clock. The carry between slices is held in a flip-flop. Only then is the result register written, and done is pulsed for one cycle.

The controller has three states:
- IDLE → SCAN when start is seen; the operands are captured.
- SCAN → RESOLVE after k+2 scan steps.
- RESOLVE → IDLE after k/32 slice additions; done is pulsed on this transition.

Operands are valid when n is odd, n < 2^(k-1), and x, y < n.

Top module: `mont_csa_mul`

## Requirements
- R1: While reset is asserted, and after it is released with no operation started, done_o is 0 and res_o is 0.
- R2: For valid operands, res_o·2^(k+2) ≡ x·y (mod n) when done_o is high.
- R3: When done_o is high, res_o < 2n.
- R4: done_o rises after the (k+3+k/32)-th rising clock edge, counting the edge that samples start_i in IDLE as the first.
- R5: done_o is high for exactly one cycle per operation.
- R6: A start_i pulse while an operation is in progress (SCAN or RESOLVE) has no effect. The result and the timing of the running operation are unchanged, and no extra done_o follows.
- R7: res_o changes only in the cycle in which done_o is high, and otherwise holds its last value.
- R8: x_i, y_i and n_i are sampled only on the accepting edge, and later changes to them do not affect the result.
- R9: If x or y is zero, res_o is exactly zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an operation when the block is idle |
| x_i | input | K | Multiplier operand, scanned from bit 0 upward |
| y_i | input | K | Multiplicand operand |
| n_i | input | K | Odd modulus |
| done_o | output | 1 | One-cycle pulse when res_o is new |
| res_o | output | K | Montgomery product, below 2n |

## Verification
The bench builds the block with K = 64. This gives two 32-bit slices, so the carry flip-flop between slices is exercised, and the reference arithmetic still fits comfortably in 256-bit bench variables.

Near-exhaustive sweeps cover every x, y pair for the small moduli 3, 5, 7 and 9. Random and extreme operands follow, with moduli close to 2^63.

For every operation the bench reduces the result modulo n, multiplies it by 2^66, and compares that with x·y modulo n. Operand inputs are scrambled after each start to confirm they were captured. One run injects a start while the block is busy, and another checks that the result holds during a long idle stretch.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
    localparam int SLICE_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_RESOLVE
    } mm_state_e;
endpackage

// File: rtl/mmul_csa_step.sv
// One scan iteration: two 3:2 compressions and a halving, all in carry-save form.
module mmul_csa_step #(
    parameter int W = 67
) (
    input  logic [W-1:0] ps_i,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] n_i,
    input  logic         xbit_i,
    output logic [W-1:0] ps_o,
    output logic [W-1:0] pc_o
);
    logic [W-1:0] add_y;
    logic [W-1:0] ss;
    logic [W-1:0] maj1;
    logic [W-1:0] sc;
    logic [W-1:0] add_n;
    logic [W-1:0] s2;

    always_comb begin
        add_y = xbit_i ? y_i : '0;
        ss    = ps_i ^ pc_i ^ add_y;
        maj1  = (ps_i & pc_i) | (ps_i & add_y) | (pc_i & add_y);
        sc    = {maj1[W-2:0], 1'b0};
        // sc[0] is always 0, so the parity of the sum is ss[0]
        add_n = ss[0] ? n_i : '0;
        s2    = ss ^ sc ^ add_n;
        // halving: the sum vector drops its (zero) low bit, and the carry vector loses its implicit shift
        ps_o  = {1'b0, s2[W-1:1]};
        pc_o  = (ss & sc) | (ss & add_n) | (sc & add_n);
    end
endmodule

// File: rtl/mmul_word_add.sv
// Narrow ripple adder used to resolve one slice per cycle.
module mmul_word_add #(
    parameter int SW = 32
) (
    input  logic [SW-1:0] a_i,
    input  logic [SW-1:0] b_i,
    input  logic          cin_i,
    output logic [SW-1:0] sum_o,
    output logic          cout_o
);
    logic [SW:0] full;

    always_comb begin
        full   = {1'b0, a_i} + {1'b0, b_i} + {{SW{1'b0}}, cin_i};
        sum_o  = full[SW-1:0];
        cout_o = full[SW];
    end
endmodule

// File: rtl/mont_csa_mul.sv
module mont_csa_mul
    import mmul_pkg::*;
#(
    parameter int K = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [K-1:0] x_i,
    input  logic [K-1:0] y_i,
    input  logic [K-1:0] n_i,
    output logic         done_o,
    output logic [K-1:0] res_o
);
    localparam int W      = K + 3;
    localparam int NSLICE = K / SLICE_W;
    localparam int ITER   = K + 2;
    localparam int ICW    = $clog2(ITER + 1);
    localparam int SCW    = $clog2(NSLICE + 1);

    mm_state_e state_q, state_d;

    logic [W-1:0]       ps_q, pc_q, y_q, n_q;
    logic [W-1:0]       ps_nx, pc_nx;
    logic [K-1:0]       xs_q;
    logic [K-1:0]       acc_q, acc_nx;
    logic [ICW-1:0]     icnt_q;
    logic [SCW-1:0]     scnt_q;
    logic               cy_q;
    logic [SLICE_W-1:0] slice_sum;
    logic               slice_cout;
    logic               last_iter, last_slice;
    logic               done_q;
    logic [K-1:0]       res_q;

    assign last_iter  = (icnt_q == ICW'(ITER - 1));
    assign last_slice = (scnt_q == SCW'(NSLICE - 1));

    mmul_csa_step #(.W(W)) step_i (
        .ps_i   (ps_q),
        .pc_i   (pc_q),
        .y_i    (y_q),
        .n_i    (n_q),
        .xbit_i (xs_q[0]),
        .ps_o   (ps_nx),
        .pc_o   (pc_nx)
    );

    mmul_word_add #(.SW(SLICE_W)) wadd_i (
        .a_i    (ps_q[SLICE_W-1:0]),
        .b_i    (pc_q[SLICE_W-1:0]),
        .cin_i  (cy_q),
        .sum_o  (slice_sum),
        .cout_o (slice_cout)
    );

    generate
        if (NSLICE == 1) begin : g_one_slice
            assign acc_nx = slice_sum;
        end else begin : g_multi_slice
            assign acc_nx = {slice_sum, acc_q[K-1:SLICE_W]};
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)    state_d = ST_SCAN;
            ST_SCAN:    if (last_iter)  state_d = ST_RESOLVE;
            ST_RESOLVE: if (last_slice) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q   <= '0;
            pc_q   <= '0;
            y_q    <= '0;
            n_q    <= '0;
            xs_q   <= '0;
            acc_q  <= '0;
            icnt_q <= '0;
            scnt_q <= '0;
            cy_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        ps_q   <= '0;
                        pc_q   <= '0;
                        xs_q   <= x_i;
                        y_q    <= {{(W-K){1'b0}}, y_i};
                        n_q    <= {{(W-K){1'b0}}, n_i};
                        icnt_q <= '0;
                    end
                end
                ST_SCAN: begin
                    ps_q   <= ps_nx;
                    pc_q   <= pc_nx;
                    xs_q   <= xs_q >> 1;
                    icnt_q <= icnt_q + 1'b1;
                    scnt_q <= '0;
                    cy_q   <= 1'b0;
                end
                ST_RESOLVE: begin
                    ps_q   <= ps_q >> SLICE_W;
                    pc_q   <= pc_q >> SLICE_W;
                    cy_q   <= slice_cout;
                    scnt_q <= scnt_q + 1'b1;
                    acc_q  <= acc_nx;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= (state_q == ST_RESOLVE) && last_slice;
            if ((state_q == ST_RESOLVE) && last_slice) res_q <= acc_nx;
        end
    end

    assign done_o = done_q;
    assign res_o  = res_q;
endmodule

// File: rtl/mmul_chk.sv
module mmul_chk #(
    parameter int K = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [K-1:0] x_i,
    input logic [K-1:0] y_i,
    input logic [K-1:0] n_i,
    input logic         done_o,
    input logic [K-1:0] res_o
);
    localparam int LAT = K + 3 + K / 32;
    localparam int CW  = $clog2(LAT + 2);

    logic         busy_q;
    logic [CW-1:0] cnt_q;
    logic [K-1:0]  n_q;
    logic          zero_q;
    logic          accept;

    assign accept = start_i && (!busy_q || done_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            n_q    <= '0;
            zero_q <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(1);
            n_q    <= n_i;
            zero_q <= (x_i == '0) || (y_i == '0);
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (busy_q && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_q && cnt_q == CW'(LAT)));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_o) |-> done_o);

    p_below_2n_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ({1'b0, res_o} < {n_q, 1'b0}));

    p_zero_operand_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zero_q) |-> (res_o == '0));
endmodule

bind mont_csa_mul mmul_chk #(.K(K)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .x_i     (x_i),
    .y_i     (y_i),
    .n_i     (n_i),
    .done_o  (done_o),
    .res_o   (res_o)
);

// File: tb/mont_csa_mul_tb.sv
module mont_csa_mul_tb_top;
    localparam int K          = 64;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = K + 3 + K / 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [K-1:0] x_i = '0, y_i = '0, n_i = '0;
    logic         done_o;
    logic [K-1:0] res_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mont_csa_mul #(.K(K)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .x_i     (x_i),
        .y_i     (y_i),
        .n_i     (n_i),
        .done_o  (done_o),
        .res_o   (res_o)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // inject: 0 none, 1 extra start while busy
    task automatic run_op(input logic [K-1:0] x, input logic [K-1:0] y, input logic [K-1:0] n,
                          input int inject, output logic [K-1:0] res);
        int cyc;
        logic [255:0] lhs, rhs, nn;
        @(negedge clk);
        x_i = x; y_i = y; n_i = n; start_i = 1'b1;
        @(posedge clk);
        cyc = 1;
        @(negedge clk);
        start_i = 1'b0;
        // R8: scramble operand inputs after the accepting edge
        x_i = ~x; y_i = x ^ y; n_i = n + 64'd2;
        while (!done_o && cyc < 4 * LAT) begin
            if (inject == 1 && (cyc == 5 || cyc == K + 3)) begin
                start_i = 1'b1;
                x_i = 64'd3; y_i = 64'd5; n_i = 64'd7;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start_i = 1'b0;
        end
        res = res_o;
        check(done_o == 1'b1, "R4 (done seen)", {255'b0, done_o}, 256'd1);
        check(cyc == LAT, inject == 1 ? "R6 (latency with busy start)" : "R4 (latency)", cyc, LAT);
        nn  = {192'b0, n};
        lhs = ((({192'b0, res} % nn) << (K + 2)) % nn);
        rhs = (({192'b0, x} * {192'b0, y}) % nn);
        check(lhs == rhs, inject == 1 ? "R6/R2 (product)" : "R2/R8 (product)", lhs, rhs);
        check({192'b0, res} < (nn << 1), "R3 (below 2n)", {192'b0, res}, nn << 1);
        @(negedge clk);
        check(done_o == 1'b0, "R5 (single pulse)", {255'b0, done_o}, 256'd0);
        check(res_o == res, "R7 (hold after done)", {192'b0, res_o}, {192'b0, res});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [K-1:0] r, held;
        logic [K-1:0] nb, xb, yb;
        bit seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(done_o == 1'b0 && res_o == '0, "R1 (during reset)", {192'b0, res_o}, 256'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0 && res_o == '0, "R1 (after reset)", {192'b0, res_o}, 256'd0);

        // near-exhaustive sweep over small moduli
        for (int n = 3; n <= 9; n += 2) begin
            for (int x = 0; x < n; x++) begin
                for (int y = 0; y < n; y++) begin
                    run_op(K'(x), K'(y), K'(n), 0, r);
                    if (x == 0 || y == 0)
                        check(r == '0, "R9 (zero operand)", {192'b0, r}, 256'd0);
                end
            end
        end

        // extreme operands near the modulus bound
        nb = 64'h7FFF_FFFF_FFFF_FFFF;
        run_op(nb - 1, nb - 1, nb, 0, r);
        run_op(nb - 2, 64'd1, nb, 0, r);
        run_op(64'd0, nb - 1, nb, 0, r);
        check(r == '0, "R9 (zero x, large n)", {192'b0, r}, 256'd0);
        run_op(nb - 1, 64'd0, nb, 0, r);
        check(r == '0, "R9 (zero y, large n)", {192'b0, r}, 256'd0);

        // random operands
        for (int i = 0; i < 120; i++) begin
            nb = {1'b0, 31'($urandom), 32'($urandom)} | 64'd1;
            if (nb < 64'd3) nb = 64'd3;
            xb = {32'($urandom), 32'($urandom)} % nb;
            yb = {32'($urandom), 32'($urandom)} % nb;
            run_op(xb, yb, nb, 0, r);
        end

        // R6: start pulses while busy are ignored
        run_op(64'h1234_5678_9ABC_DEF1, 64'h0FED_CBA9_8765_4321, 64'h7ABC_DEF0_1234_5677, 1, r);
        held = r;
        seen = 1'b0;
        for (int c = 0; c < LAT + 5; c++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        check(!seen, "R6 (no extra done)", {255'b0, seen}, 256'd0);
        check(res_o == held, "R6/R7 (result unchanged)", {192'b0, res_o}, {192'b0, held});

        // R7: long idle hold with wiggling operand inputs and no start
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            x_i = K'(c * 977); y_i = K'(c * 31); n_i = K'(c * 2 + 1);
        end
        check(res_o == held && done_o == 1'b0, "R7 (idle hold)", {192'b0, res_o}, {192'b0, held});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule